// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software with an up counter that runs on the watchdog clock. Software picks one of eight time-out intervals. When the count reaches the chosen interval, an interrupt flag is raised and a reset-delay window of selectable length opens. A counter clear during that window still saves the system. If the window closes with no clear and reset is enabled, the block sends a one-cycle reset request to the chip and records that it did so.

Software reaches the block through two 32-bit registers on a plain single-cycle read/write bus. The control register sits at byte offset 0 and the delay register at byte offset 4. An unlock input must be high for a write to change a protected field. The flags are cleared by writing 1 and are not protected. A forced-enable input keeps the watchdog running whatever software writes. A debug-halt input pauses counting unless software has chosen to keep counting under debug. When the interrupt is enabled and wake-up is also enabled, a time-out pulses a wake-up output.

There are two reset inputs. The power-on reset clears everything. The system reset clears everything except the reset-cause flag, so software can read the cause after the request has taken effect.

Top module: `wdt_window`

## Requirements
- R1: After power-on reset, both registers read 0 and irq, wake and rst_req are low.
- R2: Writing 1 to control bit 0 while unlocked restarts the count from zero and closes any open delay window. Bit 0 always reads 0.
- R3: With enable (bit 7) set, the interrupt flag (bit 3) sets after exactly 2^(4+2c) watchdog clocks, where c is the interval code in bits 10:8. irq is high when that flag and interrupt enable (bit 6) are both 1.
- R4: After a time-out, the delay window lasts 1026, 130, 18 or 3 clocks for delay code 0, 1, 2 or 3 (delay-register bits 1:0). If reset enable (bit 1) is 1 when the window expires, rst_req pulses high for exactly one cycle. If reset enable is 0, the window closes with no request.
- R5: A reset request sets the reset flag (bit 2). A system reset keeps that flag and clears every other field, including the delay code. Only power-on reset or a write of 1 clears the flag.
- R6: Writing 1 to bit 2, 3 or 5 clears that flag, with or without unlock. Writing 0 has no effect. A flag that is set and cleared in the same cycle stays set.
- R7: When a time-out occurs with wake-up enable (bit 4) and interrupt enable both 1, wake pulses for one cycle and the wake flag (bit 5) sets. If interrupt enable is 0, there is no pulse.
- R8: Clearing enable stops counting and zeroes the counter. While force_en is high, bit 7 reads 1 and counting continues even after software writes 0 to it.
- R9: While dbg_halt is high and bit 31 is 0, the counter and the delay window are frozen. With bit 31 set to 1, counting ignores dbg_halt.
- R10: With unlock low, writes leave bits 0, 1, 4, 6, 7, 10:8 and 31 of the control register, and the delay code, unchanged.
- R11: A counter clear inside an open delay window prevents the reset request. The interrupt flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock; all state is on its rising edge |
| por_n | input | 1 | Synchronous active-low power-on reset, clears all state |
| rst_n | input | 1 | Synchronous active-low system reset, keeps the reset flag |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address: 0 is control, 4 is delay |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| unlock | input | 1 | High allows writes to protected fields |
| force_en | input | 1 | Holds the watchdog enabled |
| dbg_halt | input | 1 | Processor halted by a debugger |
| irq | output | 1 | Time-out interrupt |
| wake | output | 1 | One-cycle wake-up trigger |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A wrong count or a mis-decoded interval code appears as irq rising on the wrong cycle. That error shows within at most 2^18 clocks, and within 16 clocks for code 0. A wrong delay counter or window state moves or removes the rst_req pulse, or produces a spurious one, within the 3 to 1026 clocks that follow the time-out. A corrupted configuration or flag bit shows on the very next read of bus_rdata. The bench compares the ports with its own model on every cycle, so each such fault is reported on the first cycle it becomes visible.

// File: rtl/wdt_pkg.sv
// Package wdt_pkg
// Shared register layout and configuration type for the windowed watchdog.
// Assumes a 32-bit register width; bit positions are fixed by the register map.
package wdt_pkg;

    localparam int REG_W      = 32;
    localparam int IS_W       = 3;
    localparam int DS_W       = 2;

    // control register field positions
    localparam int CTL_CLR    = 0;
    localparam int CTL_RSTE   = 1;
    localparam int CTL_RFL    = 2;
    localparam int CTL_IFL    = 3;
    localparam int CTL_WKE    = 4;
    localparam int CTL_WFL    = 5;
    localparam int CTL_IE     = 6;
    localparam int CTL_EN     = 7;
    localparam int CTL_IS_LO  = 8;
    localparam int CTL_DBG    = 31;

    // byte offsets of the two registers
    localparam int OFS_CTL    = 0;
    localparam int OFS_DLY    = 4;

    typedef struct packed {
        logic             dbg_run;
        logic [IS_W-1:0]  isel;
        logic             en;
        logic             ie;
        logic             wke;
        logic             rste;
        logic [DS_W-1:0]  dsel;
    } wdt_cfg_t;

endpackage

// File: rtl/wdt_regs.sv
// Module wdt_regs
// Register file and bus decode. Holds the protected configuration, forms the
// counter-clear and write-one-to-clear strobes, and assembles read data.
// Assumes a single-cycle bus with a full address decode; the flags live in wdt_flags.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              unlock,
    input  logic              force_en,
    input  logic              ifl,
    input  logic              rfl,
    input  logic              wfl,
    output wdt_cfg_t          cfg,
    output logic              clr_req,
    output logic              clr_ifl,
    output logic              clr_rfl,
    output logic              clr_wfl,
    output logic [REG_W-1:0]  bus_rdata
);

    wdt_cfg_t cfg_q;
    logic     hit_ctl;
    logic     hit_dly;
    logic     wr_ctl;
    logic     wr_dly;
    logic     unused_wdata;

    // decode the two register addresses
    assign hit_ctl = (bus_addr == ADDR_W'(OFS_CTL));
    assign hit_dly = (bus_addr == ADDR_W'(OFS_DLY));
    assign wr_ctl  = bus_sel && bus_wr && hit_ctl;
    assign wr_dly  = bus_sel && bus_wr && hit_dly;
    assign unused_wdata = ^bus_wdata[CTL_DBG-1:CTL_IS_LO+IS_W];

    // strobes towards the counter and the flags
    assign clr_req = wr_ctl && unlock && bus_wdata[CTL_CLR];
    assign clr_ifl = wr_ctl && bus_wdata[CTL_IFL];
    assign clr_rfl = wr_ctl && bus_wdata[CTL_RFL];
    assign clr_wfl = wr_ctl && bus_wdata[CTL_WFL];

    // protected configuration fields, written only while unlocked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            if (wr_ctl && unlock) begin
                cfg_q.dbg_run <= bus_wdata[CTL_DBG];
                cfg_q.isel    <= bus_wdata[CTL_IS_LO +: IS_W];
                cfg_q.en      <= bus_wdata[CTL_EN];
                cfg_q.ie      <= bus_wdata[CTL_IE];
                cfg_q.wke     <= bus_wdata[CTL_WKE];
                cfg_q.rste    <= bus_wdata[CTL_RSTE];
            end
            if (wr_dly && unlock) begin
                cfg_q.dsel    <= bus_wdata[DS_W-1:0];
            end
        end
    end

    // effective configuration with the forced enable folded in
    always_comb begin
        cfg    = cfg_q;
        cfg.en = cfg_q.en | force_en;
    end

    // read data mux
    always_comb begin
        bus_rdata = '0;
        if (hit_ctl) begin
            bus_rdata[CTL_DBG]               = cfg_q.dbg_run;
            bus_rdata[CTL_IS_LO +: IS_W]     = cfg_q.isel;
            bus_rdata[CTL_EN]                = cfg.en;
            bus_rdata[CTL_IE]                = cfg_q.ie;
            bus_rdata[CTL_WFL]               = wfl;
            bus_rdata[CTL_WKE]               = cfg_q.wke;
            bus_rdata[CTL_IFL]               = ifl;
            bus_rdata[CTL_RFL]               = rfl;
            bus_rdata[CTL_RSTE]              = cfg_q.rste;
        end else if (hit_dly) begin
            bus_rdata[DS_W-1:0]              = cfg_q.dsel;
        end
    end

    // R10: locked writes leave the protected fields untouched
    p_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_ctl || wr_dly) && !unlock) |=> (cfg_q == $past(cfg_q)));

endmodule

// File: rtl/wdt_core.sv
// Module wdt_core
// Time-out counter and reset-delay window. Emits a time-out event when the
// count reaches the selected interval and an expiry event when the window ends.
// Assumes en already includes the forced enable; the events are combinational.
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CNT_W   = 18,
    parameter int IS_BASE = 4,
    parameter int IS_STEP = 2,
    parameter int DLY0    = 1026,
    parameter int DLY1    = 130,
    parameter int DLY2    = 18,
    parameter int DLY3    = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            dbg_halt,
    input  logic            dbg_run,
    input  logic [IS_W-1:0] isel,
    input  logic [DS_W-1:0] dsel,
    input  logic            clr_req,
    output logic            to_evt,
    output logic            expire
);

    localparam int NUM_IS  = 1 << IS_W;
    localparam int DLY_A   = (DLY0 > DLY1) ? DLY0 : DLY1;
    localparam int DLY_B   = (DLY2 > DLY3) ? DLY2 : DLY3;
    localparam int DLY_MAX = (DLY_A > DLY_B) ? DLY_A : DLY_B;
    localparam int DLY_W   = $clog2(DLY_MAX + 1);

    logic [CNT_W-1:0] lim_tab [NUM_IS];
    logic [CNT_W-1:0] cnt;
    logic [DLY_W-1:0] dcnt;
    logic [DLY_W-1:0] dly_m1;
    logic             win;
    logic             tick;
    logic             at_lim;
    logic             at_dly;

    // last count value of each interval code
    generate
        for (genvar g = 0; g < NUM_IS; g++) begin : g_lim
            localparam longint unsigned LIMV = (64'd1 << (IS_BASE + IS_STEP * g)) - 64'd1;
            assign lim_tab[g] = CNT_W'(LIMV);
        end
    endgenerate

    // last delay count of the selected window length
    always_comb begin
        case (dsel)
            2'd0:    dly_m1 = DLY_W'(DLY0 - 1);
            2'd1:    dly_m1 = DLY_W'(DLY1 - 1);
            2'd2:    dly_m1 = DLY_W'(DLY2 - 1);
            default: dly_m1 = DLY_W'(DLY3 - 1);
        endcase
    end

    // count qualification and event detection
    assign tick   = en && !(dbg_halt && !dbg_run);
    assign at_lim = (cnt == lim_tab[isel]);
    assign at_dly = (dcnt == dly_m1);
    assign to_evt = tick && !clr_req && at_lim;
    assign expire = tick && !clr_req && win && at_dly;

    // interval counter and delay window state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            dcnt <= '0;
            win  <= 1'b0;
        end else if (!en || clr_req) begin
            cnt  <= '0;
            dcnt <= '0;
            win  <= 1'b0;
        end else if (tick) begin
            cnt <= at_lim ? '0 : cnt + 1'b1;
            if (win) begin
                if (at_dly) begin
                    win  <= 1'b0;
                    dcnt <= '0;
                end else begin
                    dcnt <= dcnt + 1'b1;
                end
            end else if (at_lim) begin
                win  <= 1'b1;
                dcnt <= '0;
            end
        end
    end

    // R2: a clear restarts the count and closes the window
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (cnt == '0) && !win);

    // R8: a disabled watchdog holds its counter at zero
    p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0) && !win);

    // R9: a halted count does not move
    p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr_req && dbg_halt && !dbg_run) |=> ($stable(cnt) && $stable(dcnt) && $stable(win)));

    // R4: a time-out outside a window opens a fresh window
    p_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (to_evt && !win) |=> (win && dcnt == '0));

endmodule

// File: rtl/wdt_flags.sv
// Module wdt_flags
// Status flags and output pulses: interrupt, wake-up and reset-cause flags,
// the interrupt level and the one-cycle wake and reset-request pulses.
// Assumes the reset-cause flag is cleared only by por_n or by a write of 1.
module wdt_flags (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic to_evt,
    input  logic expire,
    input  logic rst_en,
    input  logic irq_en,
    input  logic wake_en,
    input  logic clr_ifl,
    input  logic clr_rfl,
    input  logic clr_wfl,
    output logic ifl,
    output logic rfl,
    output logic wfl,
    output logic irq,
    output logic wake,
    output logic rst_req
);

    logic wake_set;
    logic req_set;

    assign wake_set = to_evt && wake_en && irq_en;
    assign req_set  = expire && rst_en;
    assign irq      = ifl && irq_en;

    // flags and pulses cleared by any reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ifl     <= 1'b0;
            wfl     <= 1'b0;
            wake    <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            ifl     <= to_evt   || (ifl && !clr_ifl);
            wfl     <= wake_set || (wfl && !clr_wfl);
            wake    <= wake_set;
            rst_req <= req_set;
        end
    end

    // reset-cause flag that survives the system reset
    always_ff @(posedge clk) begin
        if (!por_n) begin
            rfl <= 1'b0;
        end else if (rst_n) begin
            rfl <= req_set || (rfl && !clr_rfl);
        end
    end

    // R3: a time-out always leaves the interrupt flag set
    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        to_evt |=> ifl);

    // R6: a write of 1 clears the flag when no new event arrives
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ifl && !to_evt) |=> !ifl);

    // R4: the reset request is a single-cycle pulse
    p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R5: a reset request is always recorded
    p_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> rfl);

    // R7: a wake pulse comes with both flags set
    p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (wfl && ifl));

endmodule

// File: rtl/wdt_window.sv
// Module wdt_window
// Top level of the windowed watchdog: register file, counter with delay window
// and status flags. Assumes the bus runs on the watchdog clock and that both
// resets are synchronous and active low.
module wdt_window
    import wdt_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int CNT_W   = 18,
    parameter int IS_BASE = 4,
    parameter int IS_STEP = 2,
    parameter int DLY0    = 1026,
    parameter int DLY1    = 130,
    parameter int DLY2    = 18,
    parameter int DLY3    = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              unlock,
    input  logic              force_en,
    input  logic              dbg_halt,
    output logic              irq,
    output logic              wake,
    output logic              rst_req
);

    wdt_cfg_t cfg;
    logic     all_rst_n;
    logic     clr_req;
    logic     clr_ifl;
    logic     clr_rfl;
    logic     clr_wfl;
    logic     ifl;
    logic     rfl;
    logic     wfl;
    logic     to_evt;
    logic     expire;

    // either reset clears the ordinary state
    assign all_rst_n = por_n && rst_n;

    wdt_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (all_rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .unlock    (unlock),
        .force_en  (force_en),
        .ifl       (ifl),
        .rfl       (rfl),
        .wfl       (wfl),
        .cfg       (cfg),
        .clr_req   (clr_req),
        .clr_ifl   (clr_ifl),
        .clr_rfl   (clr_rfl),
        .clr_wfl   (clr_wfl),
        .bus_rdata (bus_rdata)
    );

    wdt_core #(
        .CNT_W   (CNT_W),
        .IS_BASE (IS_BASE),
        .IS_STEP (IS_STEP),
        .DLY0    (DLY0),
        .DLY1    (DLY1),
        .DLY2    (DLY2),
        .DLY3    (DLY3)
    ) u_core (
        .clk      (clk),
        .rst_n    (all_rst_n),
        .en       (cfg.en),
        .dbg_halt (dbg_halt),
        .dbg_run  (cfg.dbg_run),
        .isel     (cfg.isel),
        .dsel     (cfg.dsel),
        .clr_req  (clr_req),
        .to_evt   (to_evt),
        .expire   (expire)
    );

    wdt_flags u_flags (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n   (all_rst_n),
        .to_evt  (to_evt),
        .expire  (expire),
        .rst_en  (cfg.rste),
        .irq_en  (cfg.ie),
        .wake_en (cfg.wke),
        .clr_ifl (clr_ifl),
        .clr_rfl (clr_rfl),
        .clr_wfl (clr_wfl),
        .ifl     (ifl),
        .rfl     (rfl),
        .wfl     (wfl),
        .irq     (irq),
        .wake    (wake),
        .rst_req (rst_req)
    );

endmodule

// File: tb/sim_wdt_window.sv
// Bench for wdt_window: a behavioural model updated on every rising edge and
// compared with the ports at each falling edge, plus directed checks.
module sim_wdt_window;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        unlock = 1'b0;
    logic        force_en = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        irq;
    logic        wake;
    logic        rst_req;

    always #10 clk = ~clk;

    wdt_window u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .unlock(unlock), .force_en(force_en), .dbg_halt(dbg_halt),
        .irq(irq), .wake(wake), .rst_req(rst_req)
    );

    // ---------------- behavioural reference model ----------------
    int m_en, m_rste, m_ie, m_wke, m_is, m_dbg, m_dsel;
    int m_ifl, m_rfl, m_wfl, m_cnt, m_win, m_dc, m_wake, m_req;
    bit started = 0;

    function automatic int dly_len(input int code);
        case (code)
            0: return 1026;
            1: return 130;
            2: return 18;
            default: return 3;
        endcase
    endfunction

    always @(posedge clk) begin
        int  lim, dl, en_e, tick, clr, to, ex, wc, wa;
        int  n_cnt, n_win, n_dc;
        started = 1;
        wc = (bus_sel && bus_wr && bus_addr == 3'd0);
        wa = (bus_sel && bus_wr && bus_addr == 3'd4);
        if (!por_n || !rst_n) begin
            if (!por_n) m_rfl = 0;
            m_en = 0; m_rste = 0; m_ie = 0; m_wke = 0; m_is = 0; m_dbg = 0; m_dsel = 0;
            m_ifl = 0; m_wfl = 0; m_cnt = 0; m_win = 0; m_dc = 0; m_wake = 0; m_req = 0;
        end else begin
            en_e = (m_en || force_en) ? 1 : 0;
            tick = (en_e && !(dbg_halt && !m_dbg)) ? 1 : 0;
            lim  = 1 << (4 + 2 * m_is);
            dl   = dly_len(m_dsel);
            clr  = (wc && unlock && bus_wdata[0]) ? 1 : 0;
            to = 0; ex = 0;
            n_cnt = m_cnt; n_win = m_win; n_dc = m_dc;
            if (!en_e || clr) begin
                n_cnt = 0; n_win = 0; n_dc = 0;
            end else if (tick) begin
                if (m_cnt == lim - 1) begin to = 1; n_cnt = 0; end
                else n_cnt = m_cnt + 1;
                if (m_win) begin
                    if (m_dc == dl - 1) begin ex = 1; n_win = 0; n_dc = 0; end
                    else n_dc = m_dc + 1;
                end else if (to) begin
                    n_win = 1; n_dc = 0;
                end
            end
            m_wake = (to && m_wke && m_ie) ? 1 : 0;
            m_req  = (ex && m_rste) ? 1 : 0;
            m_ifl  = to     ? 1 : ((wc && bus_wdata[3]) ? 0 : m_ifl);
            m_wfl  = m_wake ? 1 : ((wc && bus_wdata[5]) ? 0 : m_wfl);
            m_rfl  = m_req  ? 1 : ((wc && bus_wdata[2]) ? 0 : m_rfl);
            m_cnt = n_cnt; m_win = n_win; m_dc = n_dc;
            if (wc && unlock) begin
                m_dbg = bus_wdata[31]; m_is = int'(bus_wdata[10:8]); m_en = bus_wdata[7];
                m_ie = bus_wdata[6]; m_wke = bus_wdata[4]; m_rste = bus_wdata[1];
            end
            if (wa && unlock) m_dsel = int'(bus_wdata[1:0]);
        end
    end

    function automatic logic [31:0] model_rd(input logic [2:0] a);
        logic [31:0] v = 32'd0;
        if (a == 3'd0) begin
            v[31] = m_dbg[0]; v[10:8] = m_is[2:0]; v[7] = m_en[0] | force_en;
            v[6] = m_ie[0]; v[5] = m_wfl[0]; v[4] = m_wke[0]; v[3] = m_ifl[0];
            v[2] = m_rfl[0]; v[1] = m_rste[0];
        end else if (a == 3'd4) begin
            v[1:0] = m_dsel[1:0];
        end
        return v;
    endfunction

    // ---------------- counters and reporting ----------------
    int m_total = 0, m_bad = 0, d_total = 0, d_bad = 0, ncyc = 0;

    task automatic report();
        $display("  test done: total=%0d bad=%0d", m_total + d_total, m_bad + d_bad);
    endtask

    // per-cycle comparison with the model, plus the watchdog
    always @(negedge clk) begin
        logic [31:0] er;
        ncyc++;
        if (ncyc > 150000) begin
            m_total++; m_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            report();
            $finish;
        end
        if (started) begin
            er = model_rd(bus_addr);
            m_total++;
            if (irq !== (m_ifl[0] && m_ie[0])) begin
                m_bad++; $display("FAIL R3 irq actual=%b expected=%b", irq, m_ifl[0] && m_ie[0]);
            end
            m_total++;
            if (wake !== m_wake[0]) begin
                m_bad++; $display("FAIL R7 wake actual=%b expected=%b", wake, m_wake[0]);
            end
            m_total++;
            if (rst_req !== m_req[0]) begin
                m_bad++; $display("FAIL R4 rst_req actual=%b expected=%b", rst_req, m_req[0]);
            end
            m_total++;
            if (bus_rdata !== er) begin
                m_bad++; $display("FAIL R10 rdata actual=%h expected=%h", bus_rdata, er);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        d_total++;
        if (!ok) begin
            d_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_por();
        por_n = 1'b0; rst_n = 1'b0;
        steps(2);
        por_n = 1'b1; rst_n = 1'b1;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d, input logic ul);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; unlock = ul;
        step();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 32'd0; unlock = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq && n < 5000) begin step(); n++; end
    endtask

    task automatic wait_req(output int n);
        n = 0;
        while (!rst_req && n < 5000) begin step(); n++; end
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        int n;
        int seen;
        do_por();

        // R1: reset state
        rd_chk(3'd0, 32'h0, "R1 ctrl after reset");
        rd_chk(3'd4, 32'h0, "R1 delay after reset");
        chk(!irq && !wake && !rst_req, "R1 outputs after reset", {irq, wake, rst_req}, 0);

        // R10: locked writes ignored
        wr_reg(3'd0, 32'h8000_07D3, 1'b0);
        rd_chk(3'd0, 32'h0, "R10 locked ctrl write");
        wr_reg(3'd4, 32'h3, 1'b0);
        rd_chk(3'd4, 32'h0, "R10 locked delay write");

        // R3: interval codes 0..3
        for (int c = 0; c < 4; c++) begin
            do_por();
            wr_reg(3'd0, (32'(c) << 8) | 32'hC0, 1'b1);
            wait_irq(n);
            chk(n == (1 << (4 + 2 * c)), "R3 interval length", n, 1 << (4 + 2 * c));
        end
        // R3: masked interrupt still sets the flag
        do_por();
        wr_reg(3'd0, 32'h80, 1'b1);
        steps(20);
        chk(!irq, "R3 masked irq", irq, 0);
        rd_chk(3'd0, 32'h88, "R3 flag without enable");

        // R4 and R5: each delay code, then system reset keeps only the cause flag
        for (int d = 3; d >= 0; d--) begin
            do_por();
            wr_reg(3'd4, 32'(d), 1'b1);
            wr_reg(3'd0, 32'hC2, 1'b1);
            wait_irq(n);
            wait_req(n);
            chk(n == dly_len(d), "R4 delay window length", n, dly_len(d));
            step();
            chk(!rst_req, "R4 single-cycle request", rst_req, 0);
            rst_n = 1'b0; step(); rst_n = 1'b1;
            rd_chk(3'd0, 32'h4, "R5 cause flag kept");
            rd_chk(3'd4, 32'h0, "R5 delay code cleared");
        end
        // R6: writing 0 keeps the cause flag, writing 1 clears it without unlock
        wr_reg(3'd0, 32'h0, 1'b1);
        rd_chk(3'd0, 32'h4, "R6 write zero no effect");
        wr_reg(3'd0, 32'h4, 1'b0);
        rd_chk(3'd0, 32'h0, "R6 write one clears");

        // R4: reset disabled gives no request
        do_por();
        wr_reg(3'd4, 32'h3, 1'b1);
        wr_reg(3'd0, 32'hC0, 1'b1);
        wait_irq(n);
        seen = 0;
        for (int i = 0; i < 10; i++) begin step(); if (rst_req) seen++; end
        chk(seen == 0, "R4 no request when disabled", seen, 0);
        rd_chk(3'd0, 32'hC8, "R4 no cause flag when disabled");

        // R11 and R2: clear inside the window prevents the reset
        do_por();
        wr_reg(3'd4, 32'h1, 1'b1);
        wr_reg(3'd0, 32'h2C2, 1'b1);
        wait_irq(n);
        steps(50);
        wr_reg(3'd0, 32'h2C3, 1'b1);
        rd_chk(3'd0, 32'h2CA, "R2 clear bit reads zero");
        seen = 0;
        for (int i = 0; i < 300; i++) begin step(); if (rst_req) seen++; end
        chk(seen == 0, "R11 clear in window", seen, 0);
        chk(irq, "R11 interrupt flag kept", irq, 1);

        // R2: clear restarts the interval
        do_por();
        wr_reg(3'd0, 32'hC0, 1'b1);
        steps(10);
        wr_reg(3'd0, 32'hC1, 1'b1);
        wait_irq(n);
        chk(n == 16, "R2 restart after clear", n, 16);

        // R10: clear without unlock is ignored
        do_por();
        wr_reg(3'd0, 32'hC0, 1'b1);
        steps(10);
        wr_reg(3'd0, 32'hC1, 1'b0);
        wait_irq(n);
        chk(n == 5, "R10 locked clear ignored", n, 5);

        // R7: wake pulse
        do_por();
        wr_reg(3'd0, 32'hD0, 1'b1);
        n = 0;
        while (!wake && n < 100) begin step(); n++; end
        chk(n == 16 && irq, "R7 wake at time-out", n, 16);
        rd_chk(3'd0, 32'hF8, "R7 wake flag");
        // R6: both flags cleared by writing ones without unlock
        wr_reg(3'd0, 32'h28, 1'b0);
        chk(!wake, "R7 wake one cycle", wake, 0);
        rd_chk(3'd0, 32'hD0, "R6 flags cleared");
        // R7: no wake without interrupt enable
        do_por();
        wr_reg(3'd0, 32'h90, 1'b1);
        seen = 0;
        for (int i = 0; i < 20; i++) begin step(); if (wake) seen++; end
        chk(seen == 0, "R7 no wake when masked", seen, 0);
        rd_chk(3'd0, 32'h98, "R7 no wake flag");

        // R8: disable stops and zeroes the counter
        do_por();
        wr_reg(3'd0, 32'hC0, 1'b1);
        steps(10);
        wr_reg(3'd0, 32'h40, 1'b1);
        steps(30);
        chk(!irq, "R8 stopped", irq, 0);
        rd_chk(3'd0, 32'h40, "R8 enable cleared");
        wr_reg(3'd0, 32'hC0, 1'b1);
        wait_irq(n);
        chk(n == 16, "R8 counter zeroed", n, 16);
        // R8: forced enable
        do_por();
        force_en = 1'b1;
        rd_chk(3'd0, 32'h80, "R8 forced enable reads one");
        wr_reg(3'd0, 32'h40, 1'b1);
        wait_irq(n);
        chk(irq && n <= 16, "R8 forced enable keeps counting", n, 16);
        force_en = 1'b0;

        // R9: debug halt pauses counting
        do_por();
        wr_reg(3'd0, 32'hC0, 1'b1);
        steps(5);
        dbg_halt = 1'b1; steps(10); dbg_halt = 1'b0;
        wait_irq(n);
        chk(n == 11, "R9 halt pauses", n, 11);
        // R9: debug bit keeps counting
        do_por();
        wr_reg(3'd0, 32'h8000_00C0, 1'b1);
        steps(5);
        dbg_halt = 1'b1; steps(10); dbg_halt = 1'b0;
        wait_irq(n);
        chk(n == 1, "R9 run under debug", n, 1);

        steps(2);
        report();
        $finish;
    end

endmodule